// File: doc/BRIEF.md
# One-Shot Delayed Pulse Timer

This block is a single-channel-group timer that emits one delayed pulse per software trigger. While enabled it sits waiting with its counter parked. A one-cycle trigger strobe restarts the counter from zero, and the counter then climbs by one on each selected count tick. Each delay channel raises its pulse output when the counter reaches that channel's delay value. All pulses drop together on the tick that follows the counter reaching the end value. The counter then parks at zero until the next trigger.

The count tick comes either from an internal count-clock enable or from an external event strobe, picked by a source-select input. The end value and the delay values are sampled when a trigger is accepted, so a run keeps the timing it started with. Each match also gives a one-cycle interrupt strobe. Clearing the enable input aborts any run at once.

Top module: `oneshot_pulse_timer`

## Requirements
- R1: While `run_en` is 0, the register update forces `count` to all ones (FFFFH) and holds `pulse_out`, `irq_end` and `irq_dly` at 0. Triggers and ticks have no effect while disabled.
- R2: While enabled and not running, `count` holds its value whatever the ticks do. That value is FFFFH after enabling and 0000H after a completed run.
- R3: A `sw_trig` pulse sampled while enabled and not running starts a run. On the next cycle `count` is 0000H, and `cmp_end` and `cmp_dly` are captured as that value.
- R4: While running, each sampled count tick with `count` different from the captured end value makes `count` one larger on the next cycle.
- R5: With `src_sel` at 0 the tick is `cnt_tick`, and `evt_tick` is ignored. With `src_sel` at 1 the tick is `evt_tick`, and `cnt_tick` is ignored.
- R6: `pulse_out[b]` goes to 1 in the cycle in which `count` first takes the captured delay value of channel b. Channel b uses bits [16b+15:16b] of `cmp_dly`. The delay is therefore that value in ticks after the trigger.
- R7: A tick sampled while `count` equals the captured end value ends the run. On the next cycle `count` is 0000H and every pulse is 0. A pulse is high for (end − delay + 1) ticks. A channel whose delay exceeds the end value never pulses.
- R8: A `sw_trig` sampled during a run is ignored: neither the count nor the outputs are affected.
- R9: `irq_end` is a one-cycle strobe in the cycle `count` takes the end value. `irq_dly[b]` is a one-cycle strobe in the cycle `count` takes channel b's delay value. Value 0 is reached at the trigger itself.
- R10: Changes to `cmp_end` or `cmp_dly` during a run do not affect that run.
- R11: Clearing `run_en` during a run gives, on the next cycle, `count` = FFFFH, all pulses 0 and no strobes.
- R12: After reset, `count` is FFFFH and all pulse and strobe outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Enable; 0 aborts and parks the counter at FFFFH |
| src_sel | input | 1 | Count source: 0 internal tick, 1 external event |
| cnt_tick | input | 1 | Internal count-clock enable, one cycle per tick |
| evt_tick | input | 1 | External event strobe, one cycle per event |
| sw_trig | input | 1 | Software trigger strobe |
| cmp_end | input | 16 | End (period) compare value |
| cmp_dly | input | 48 | Three delay compare values, channel b in bits [16b+15:16b] |
| count | output | 16 | Current counter value |
| pulse_out | output | 3 | Registered active-high pulse per delay channel |
| irq_end | output | 1 | End-match strobe |
| irq_dly | output | 3 | Delay-match strobe per channel |

## Verification
Every output is a register, so the effect of a trigger, a tick or a change of enable shows one clock edge after the edge that samples it. A trigger gives count 0000H and any zero-value match on the next cycle. A delay of d shows as a pulse d ticks later, and the end of a run shows one tick after the end match. The bench sets its inputs after a falling edge and moves its behavioural model forward at the rising edge that samples them. It then compares all outputs at the next falling edge, so each result is checked in exactly the cycle it is due. Explicit measurements of delay and width across whole runs back up this per-cycle comparison.

// File: rtl/oneshot_pulse_timer.sv
module oneshot_pulse_timer #(
  parameter int W    = 16,
  parameter int NDLY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              src_sel,
  input  logic              cnt_tick,
  input  logic              evt_tick,
  input  logic              sw_trig,
  input  logic [W-1:0]      cmp_end,
  input  logic [NDLY*W-1:0] cmp_dly,
  output logic [W-1:0]      count,
  output logic [NDLY-1:0]   pulse_out,
  output logic              irq_end,
  output logic [NDLY-1:0]   irq_dly
);

  localparam logic [W-1:0] CNT_PARK = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] end_q;
  logic         run_q;
  logic         irq_end_q;

  wire tick    = src_sel ? evt_tick : cnt_tick;
  wire start   = run_en & ~run_q & sw_trig;
  wire step    = run_en & run_q & tick;
  wire at_end  = (cnt_q == end_q);
  wire finish  = step & at_end;
  wire advance = step & ~at_end;
  wire arrive  = start | advance;

  wire [W-1:0] cnt_nxt = start ? '0 : cnt_q + 1'b1;
  wire [W-1:0] end_sel = start ? cmp_end : end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_PARK;
      run_q <= 1'b0;
      end_q <= '0;
    end else if (!run_en) begin
      cnt_q <= CNT_PARK;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      run_q <= 1'b1;
      end_q <= cmp_end;
    end else if (finish) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (advance) begin
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_end_q <= 1'b0;
    else        irq_end_q <= arrive && (cnt_nxt == end_sel);
  end

  assign count   = cnt_q;
  assign irq_end = irq_end_q;

  for (genvar i = 0; i < NDLY; i++) begin : g_ch
    logic [W-1:0] dly_q;
    logic         pls_q;
    logic         irq_q;
    wire  [W-1:0] dly_sel = start ? cmp_dly[i*W +: W] : dly_q;
    wire          hit     = arrive && (cnt_nxt == dly_sel);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dly_q <= '0;
        pls_q <= 1'b0;
        irq_q <= 1'b0;
      end else begin
        if (start) dly_q <= cmp_dly[i*W +: W];
        irq_q <= hit;
        if (!run_en || finish) pls_q <= 1'b0;
        else if (hit)          pls_q <= 1'b1;
      end
    end

    assign pulse_out[i] = pls_q;
    assign irq_dly[i]   = irq_q;

    assert_pulse_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pls_q |-> run_q);
  end

  assert_disabled_park_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (count == CNT_PARK && pulse_out == '0 && !irq_end && irq_dly == '0));

  assert_trigger_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count == '0));

  assert_step_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (count == $past(cnt_q) + 1'b1));

  assert_end_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (count == '0 && pulse_out == '0));

  assert_trig_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && run_q && !tick && sw_trig) |=> $stable(count));

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end |=> !irq_end);

endmodule

// File: tb/sim_oneshot_pulse_timer.sv
module sim_oneshot_pulse_timer;
  logic        clk = 0, rst_n = 0;
  logic        run_en = 0, src_sel = 0, cnt_tick = 0, evt_tick = 0, sw_trig = 0;
  logic [15:0] cmp_end = 0;
  logic [47:0] cmp_dly = 0;
  logic [15:0] count;
  logic [2:0]  pulse_out, irq_dly;
  logic        irq_end;

  oneshot_pulse_timer u0 (.clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel),
    .cnt_tick(cnt_tick), .evt_tick(evt_tick), .sw_trig(sw_trig), .cmp_end(cmp_end),
    .cmp_dly(cmp_dly), .count(count), .pulse_out(pulse_out), .irq_end(irq_end),
    .irq_dly(irq_dly));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R12";

  int m_cnt = 65535, m_end = 0;
  int m_dly[3];
  bit m_run = 0, m_irq_end = 0;
  bit m_pulse[3], m_irq[3];

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  function automatic void reach(int v);
    if (v == m_end) m_irq_end = 1;
    for (int b = 0; b < 3; b++)
      if (v == m_dly[b]) begin m_irq[b] = 1; m_pulse[b] = 1; end
  endfunction

  function automatic void model();
    bit tk;
    tk = src_sel ? evt_tick : cnt_tick;
    m_irq_end = 0;
    for (int b = 0; b < 3; b++) m_irq[b] = 0;
    if (!run_en) begin
      m_cnt = 65535; m_run = 0;
      for (int b = 0; b < 3; b++) m_pulse[b] = 0;
    end else if (!m_run) begin
      if (sw_trig) begin
        m_run = 1; m_cnt = 0; m_end = cmp_end;
        for (int b = 0; b < 3; b++) m_dly[b] = cmp_dly[b*16 +: 16];
        reach(0);
      end
    end else if (tk) begin
      if (m_cnt == m_end) begin
        m_run = 0; m_cnt = 0;
        for (int b = 0; b < 3; b++) m_pulse[b] = 0;
      end else begin
        m_cnt++; reach(m_cnt);
      end
    end
  endfunction

  task automatic compare();
    chk("count", count, m_cnt);
    chk("irq_end", irq_end, m_irq_end);
    for (int b = 0; b < 3; b++) begin
      chk("pulse", pulse_out[b], m_pulse[b]);
      chk("irq_dly", irq_dly[b], m_irq[b]);
    end
  endtask

  task automatic cyc(bit trg, bit ct, bit et);
    sw_trig = trg; cnt_tick = ct; evt_tick = et;
    @(posedge clk);
    model();
    @(negedge clk);
    compare();
  endtask

  task automatic setcmp(int e, int d0, int d1, int d2);
    cmp_end = e[15:0];
    cmp_dly = {d2[15:0], d1[15:0], d0[15:0]};
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int dly_meas, wid_meas;
    bit seen;
    repeat (3) @(negedge clk);
    cur_req = "R12";
    compare();
    rst_n = 1;
    @(negedge clk);
    compare();

    cur_req = "R1";
    setcmp(4, 1, 2, 3);
    for (int k = 0; k < 6; k++) cyc(k[0], 1, 1);

    cur_req = "R2";
    run_en = 1;
    for (int k = 0; k < 5; k++) cyc(0, 1, 0);

    cur_req = "R3";
    setcmp(10, 3, 5, 12);
    cyc(1, 0, 0);
    cur_req = "R6";
    dly_meas = 0; wid_meas = 0; seen = 0;
    for (int k = 0; k < 14; k++) begin
      cyc(0, 1, 0);
      if (!seen) dly_meas++;
      if (pulse_out[0]) begin seen = 1; wid_meas++; end
    end
    chk("delay ticks ch0", dly_meas, 3);
    cur_req = "R7";
    chk("width ticks ch0", wid_meas, 8);
    chk("count parked", count, 0);
    chk("ch2 never pulses", pulse_out[2], 0);

    cur_req = "R2";
    for (int k = 0; k < 4; k++) cyc(0, 1, 1);

    cur_req = "R5";
    src_sel = 1;
    setcmp(6, 2, 0, 6);
    cyc(1, 0, 0);
    for (int k = 0; k < 30; k++) cyc(0, 1, (k % 3) == 0);
    src_sel = 0;
    setcmp(5, 1, 4, 5);
    cyc(1, 0, 0);
    for (int k = 0; k < 24; k++) cyc(0, (k % 2) == 1, 1);

    cur_req = "R8";
    setcmp(8, 2, 3, 4);
    cyc(1, 0, 0);
    for (int k = 0; k < 14; k++) cyc(1, k[0], 0);
    cyc(0, 1, 0);

    cur_req = "R10";
    setcmp(7, 1, 2, 3);
    cyc(1, 0, 0);
    setcmp(2, 0, 0, 0);
    for (int k = 0; k < 12; k++) cyc(0, 1, 0);

    cur_req = "R11";
    setcmp(20, 1, 2, 3);
    cyc(1, 0, 0);
    for (int k = 0; k < 5; k++) cyc(0, 1, 0);
    run_en = 0;
    cyc(0, 1, 0);
    cyc(1, 1, 0);
    run_en = 1;
    cyc(0, 1, 0);

    cur_req = "R9";
    setcmp(0, 0, 0, 1);
    cyc(1, 0, 0);
    for (int k = 0; k < 4; k++) cyc(0, 1, 0);
    setcmp(65535, 65534, 65535, 2);
    cyc(1, 0, 0);
    for (int k = 0; k < 5; k++) cyc(0, 1, 0);

    cur_req = "R4";
    setcmp(40, 10, 20, 30);
    cyc(1, 0, 0);
    for (int k = 0; k < 60; k++) cyc(0, (k % 4) != 2, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule